// File: doc/BRIEF.md
# Fast Ethernet PHY Management Register Model

This block models the management register file of a fast Ethernet PHY. It is seen through a parallel port that carries a PHY address, a register index, write data and separate read and write strobes, which is the shape a serial management controller produces once a frame has been deframed. The serial framing, the analog line side and autonegotiation signalling are not modelled. The line side is reduced to a single link-up input.

The block holds four registers: control, status, local advertisement and link-partner ability. It also returns two fixed identifier words. A change on the link input rewrites the status and link-partner registers with no bus access. Software can reset the register file by writing the reset bit of the control register. That reset reloads the defaults and then applies the present link state.

Register indices follow the usual management layout because management software decodes them:
- 0 is control.
- 1 is status.
- 2 and 3 are the identifiers.
- 4 is advertisement.
- 5 is link partner.
- Every other index reads as zero.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset the read data is 0x0000. Control reads 0x3100 (bit 13 speed 100, bit 12 autoneg enable, bit 8 full duplex). Status reads 0x7848 (bits 14..11 abilities, bit 6 preamble suppression, bit 3 autoneg ability). Advertisement reads 0x01E1 (bits 8..5 abilities, selector 0x01). Link partner reads 0x0080. All of these are link-down values.
- R2: A read whose PHY address differs from the strap parameter returns 0xFFFF.
- R3: A write whose PHY address differs from the strap parameter changes no register.
- R4: Read data is registered. It shows the addressed value one cycle after the read strobe and holds while no read strobe is given.
- R5: Link up sets status bit 2 (link) and bit 5 (autoneg complete), giving 0x786C. It ORs bits 8, 6, 5 and 0 into the link-partner register, giving 0x01E1. Both take effect on the first clock edge that sees the new input level.
- R6: Link down clears status bits 2 and 5 and overwrites the link-partner register with 0x0080, on the first clock edge that sees the new level.
- R7: A control write with bit 15 set reloads control 0x3100 and advertisement 0x01E1. It sets status and link partner to the values for the current link input. The written word is not stored.
- R8: A control write with bit 15 clear stores the word as written. An advertisement write (index 4) stores the word as written.
- R9: Writes to status (1), identifiers (2, 3), link partner (5) and every index of 6 or above change nothing.
- R10: Index 2 reads the ID1 parameter and index 3 reads the ID2 parameter.
- R11: Reads of any index of 6 or above return 0x0000.
- R12: A read and a write to the same register in one cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phyAddr | input | ADDR_W | PHY address of the access |
| regIdx | input | IDX_W | Register index of the access |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| linkUp | input | 1 | Line-side link indication |
| rdData | output | 16 | Registered read data |

## Verification
The bench builds the block with strap address 19 and ID words 0x8201 and 0x0C21. A strap address other than zero lets reads and writes to address 0 act as foreign accesses. A nonzero ID2 separates an identifier read from the all-zero response of unimplemented indices. The index width of 5 brings index 31 within reach, and several indices above 5 are read and written to cover the zero and ignore paths.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int DATA_W = 16;
  typedef logic [DATA_W-1:0] word_t;

  // Register indices decoded by management software
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_ID1  = 2;
  localparam int IDX_ID2  = 3;
  localparam int IDX_ADV  = 4;
  localparam int IDX_LPA  = 5;
  localparam int NUM_IMPL = 6;

  // Control bits
  localparam int CTRL_SWRST_BIT = 15;
  localparam int CTRL_SPEED_BIT = 13;
  localparam int CTRL_ANEN_BIT  = 12;
  localparam int CTRL_FDX_BIT   = 8;

  // Status bits
  localparam int STAT_TXFD_BIT  = 14;
  localparam int STAT_TXHD_BIT  = 13;
  localparam int STAT_TFD_BIT   = 12;
  localparam int STAT_THD_BIT   = 11;
  localparam int STAT_PRSUP_BIT = 6;
  localparam int STAT_ANDONE_BIT = 5;
  localparam int STAT_ANABL_BIT = 3;
  localparam int STAT_LINK_BIT  = 2;

  // Ability bits shared by advertisement and link partner
  localparam int ABL_TXFD_BIT = 8;
  localparam int ABL_TX_BIT   = 7;
  localparam int ABL_TFD_BIT  = 6;
  localparam int ABL_T_BIT    = 5;
  localparam int ABL_SEL_BIT  = 0;

  localparam word_t CTRL_DEF = word_t'((1 << CTRL_SPEED_BIT) | (1 << CTRL_ANEN_BIT) |
                                       (1 << CTRL_FDX_BIT));
  localparam word_t STAT_DEF = word_t'((1 << STAT_TXFD_BIT) | (1 << STAT_TXHD_BIT) |
                                       (1 << STAT_TFD_BIT) | (1 << STAT_THD_BIT) |
                                       (1 << STAT_PRSUP_BIT) | (1 << STAT_ANABL_BIT));
  localparam word_t STAT_LINK_MASK = word_t'((1 << STAT_LINK_BIT) | (1 << STAT_ANDONE_BIT));
  localparam word_t ADV_DEF  = word_t'((1 << ABL_TXFD_BIT) | (1 << ABL_TX_BIT) |
                                       (1 << ABL_TFD_BIT) | (1 << ABL_T_BIT) |
                                       (1 << ABL_SEL_BIT));
  localparam word_t LPA_DOWN = word_t'(1 << ABL_TX_BIT);
  localparam word_t LPA_UP_MASK = word_t'((1 << ABL_TXFD_BIT) | (1 << ABL_TFD_BIT) |
                                          (1 << ABL_T_BIT) | (1 << ABL_SEL_BIT));

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STAT,
    SEL_ID1,
    SEL_ID2,
    SEL_ADV,
    SEL_LPA,
    SEL_ZERO,
    SEL_FLOAT
  } rdSel_e;

  typedef struct packed {
    logic   rdTake;
    rdSel_e rdSel;
    logic   wrCtrl;
    logic   wrSwReset;
    logic   wrAdv;
  } strobe_t;

  function automatic word_t statForLink(word_t cur, logic up);
    return up ? (cur | STAT_LINK_MASK) : (cur & ~STAT_LINK_MASK);
  endfunction

  function automatic word_t lpaForLink(word_t cur, logic up);
    return up ? (cur | LPA_UP_MASK) : LPA_DOWN;
  endfunction

endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W = 5,
  parameter logic [ADDR_W-1:0] STRAP_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              swResetReq,
  input  logic              rdEn,
  input  logic              wrEn,
  output strobe_t           strb
);

  logic                addrHit;
  logic [NUM_IMPL-1:0] idxHit;

  assign addrHit = (phyAddr == STRAP_ADDR);

  for (genvar g = 0; g < NUM_IMPL; g++) begin : g_idx
    assign idxHit[g] = (regIdx == IDX_W'(g));
  end

  rdSel_e selNext;
  always_comb begin
    if (!addrHit)              selNext = SEL_FLOAT;
    else if (idxHit[IDX_CTRL]) selNext = SEL_CTRL;
    else if (idxHit[IDX_STAT]) selNext = SEL_STAT;
    else if (idxHit[IDX_ID1])  selNext = SEL_ID1;
    else if (idxHit[IDX_ID2])  selNext = SEL_ID2;
    else if (idxHit[IDX_ADV])  selNext = SEL_ADV;
    else if (idxHit[IDX_LPA])  selNext = SEL_LPA;
    else                       selNext = SEL_ZERO;
  end

  always_comb begin
    strb.rdTake    = rdEn;
    strb.rdSel     = selNext;
    strb.wrCtrl    = wrEn && addrHit && idxHit[IDX_CTRL] && !swResetReq;
    strb.wrSwReset = wrEn && addrHit && idxHit[IDX_CTRL] && swResetReq;
    strb.wrAdv     = wrEn && addrHit && idxHit[IDX_ADV];
  end

  // R3/R9: at most one register write strobe per cycle, none for a foreign address
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrSwReset, strb.wrAdv}));
  p_foreign_nowrite_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phyAddr != STRAP_ADDR) |-> !(strb.wrCtrl || strb.wrSwReset || strb.wrAdv));

endmodule

// File: rtl/phy_mgmt_datapath.sv
module phy_mgmt_datapath
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] ID1_WORD = 16'h8201,
  parameter logic [15:0] ID2_WORD = 16'h0000
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  word_t   wrData,
  input  logic    linkUp,
  output word_t   rdData
);

  word_t ctrlReg, statReg, advReg, lpaReg, rdReg;
  logic  linkSeen;
  logic  linkEvent;

  assign linkEvent = (linkUp != linkSeen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_DEF;
      statReg  <= STAT_DEF;
      advReg   <= ADV_DEF;
      lpaReg   <= LPA_DOWN;
      linkSeen <= 1'b0;
    end else if (strb.wrSwReset) begin
      ctrlReg  <= CTRL_DEF;
      advReg   <= ADV_DEF;
      statReg  <= statForLink(STAT_DEF, linkUp);
      lpaReg   <= lpaForLink(LPA_DOWN, linkUp);
      linkSeen <= linkUp;
    end else begin
      if (strb.wrCtrl) ctrlReg <= wrData;
      if (strb.wrAdv)  advReg  <= wrData;
      if (linkEvent) begin
        statReg  <= statForLink(statReg, linkUp);
        lpaReg   <= lpaForLink(lpaReg, linkUp);
        linkSeen <= linkUp;
      end
    end
  end

  word_t rdMux;
  always_comb begin
    unique case (strb.rdSel)
      SEL_CTRL:  rdMux = ctrlReg;
      SEL_STAT:  rdMux = statReg;
      SEL_ID1:   rdMux = ID1_WORD;
      SEL_ID2:   rdMux = ID2_WORD;
      SEL_ADV:   rdMux = advReg;
      SEL_LPA:   rdMux = lpaReg;
      SEL_ZERO:  rdMux = '0;
      default:   rdMux = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdReg <= '0;
    else if (strb.rdTake) rdReg <= rdMux;
  end

  assign rdData = rdReg;

  // R5: a high link input is reflected one edge later
  p_link_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    linkUp |=> (statReg[STAT_LINK_BIT] && statReg[STAT_ANDONE_BIT] &&
                lpaReg == (LPA_DOWN | LPA_UP_MASK)));
  // R6: a low link input is reflected one edge later
  p_link_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> (!statReg[STAT_LINK_BIT] && !statReg[STAT_ANDONE_BIT] &&
                 lpaReg == LPA_DOWN));
  // R7: software reset restores control and advertisement defaults
  p_swreset_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSwReset |=> (ctrlReg == CTRL_DEF && advReg == ADV_DEF));
  // R8: a plain control write is kept as written
  p_ctrl_store_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> (ctrlReg == $past(wrData)));
  // R9: ability bits of status never change
  p_stat_abl_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statReg & ~STAT_LINK_MASK) == STAT_DEF);

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W = 5,
  parameter logic [ADDR_W-1:0] STRAP_ADDR = '0,
  parameter logic [15:0] ID1_WORD = 16'h8201,
  parameter logic [15:0] ID2_WORD = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [15:0]       wrData,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              linkUp,
  output logic [15:0]       rdData
);

  strobe_t strb;

  phy_mgmt_ctrl #(
    .ADDR_W(ADDR_W),
    .IDX_W(IDX_W),
    .STRAP_ADDR(STRAP_ADDR)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .phyAddr(phyAddr),
    .regIdx(regIdx),
    .swResetReq(wrData[CTRL_SWRST_BIT]),
    .rdEn(rdEn),
    .wrEn(wrEn),
    .strb(strb)
  );

  phy_mgmt_datapath #(
    .ID1_WORD(ID1_WORD),
    .ID2_WORD(ID2_WORD)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wrData(wrData),
    .linkUp(linkUp),
    .rdData(rdData)
  );

  // R2: foreign reads float high
  p_float_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && phyAddr != STRAP_ADDR) |=> (rdData == 16'hFFFF));
  // R4: read data holds without a strobe
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
  // R10: identifier words
  p_id1_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && phyAddr == STRAP_ADDR && regIdx == IDX_W'(IDX_ID1)) |=> (rdData == ID1_WORD));
  // R11: unimplemented indices read zero
  p_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && phyAddr == STRAP_ADDR && regIdx >= IDX_W'(NUM_IMPL)) |=> (rdData == 16'h0000));

endmodule

// File: tb/tb_phy_mgmt_regs.sv
`timescale 1ns/1ps
module tb_phy_mgmt_regs;

  localparam logic [4:0]  STRAP = 5'd19;
  localparam logic [15:0] ID1 = 16'h8201;
  localparam logic [15:0] ID2 = 16'h0C21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regIdx = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        linkUp = 1'b0;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phy_mgmt_regs #(
    .ADDR_W(5), .IDX_W(5), .STRAP_ADDR(STRAP), .ID1_WORD(ID1), .ID2_WORD(ID2)
  ) dut (
    .clk(clk), .rstN(rstN), .phyAddr(phyAddr), .regIdx(regIdx), .wrData(wrData),
    .rdEn(rdEn), .wrEn(wrEn), .linkUp(linkUp), .rdData(rdData)
  );

  // Behavioural reference model
  int mCtrl = 'h3100, mStat = 'h7848, mAdv = 'h01E1, mLpa = 'h0080, mRd = 0;
  bit mLink = 1'b0;

  function automatic int modelRead(logic [4:0] a, logic [4:0] i);
    if (a != STRAP) return 'hFFFF;
    case (i)
      5'd0: return mCtrl;
      5'd1: return mStat;
      5'd2: return int'(ID1);
      5'd3: return int'(ID2);
      5'd4: return mAdv;
      5'd5: return mLpa;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = 'h3100; mStat = 'h7848; mAdv = 'h01E1; mLpa = 'h0080; mRd = 0; mLink = 1'b0;
    end else begin
      int nextRd;
      nextRd = rdEn ? modelRead(phyAddr, regIdx) : mRd;
      if (wrEn && phyAddr == STRAP) begin
        if (regIdx == 5'd0) begin
          if (wrData[15]) begin
            mCtrl = 'h3100; mAdv = 'h01E1;
            mStat = linkUp ? 'h786C : 'h7848;
            mLpa  = linkUp ? 'h01E1 : 'h0080;
            mLink = linkUp;
          end else begin
            mCtrl = int'(wrData);
          end
        end else if (regIdx == 5'd4) begin
          mAdv = int'(wrData);
        end
      end
      if (linkUp != mLink) begin
        mLink = linkUp;
        mStat = linkUp ? (mStat | 'h0024) : (mStat & ~'h0024);
        mLpa  = linkUp ? (mLpa | 'h0161) : 'h0080;
      end
      mRd = nextRd;
    end
  end

  // Per-cycle comparison against the model (R4 timing of read data)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (rdData !== mRd[15:0]) begin
        errors++;
        $display("FAIL R4 model compare: actual %h expected %h", rdData, mRd[15:0]);
      end
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, logic [4:0] i, logic [15:0] exp, string tag);
    rdEn = 1'b1; phyAddr = a; regIdx = i;
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, rdData, exp);
  endtask

  task automatic wr(logic [4:0] a, logic [4:0] i, logic [15:0] d);
    wrEn = 1'b1; phyAddr = a; regIdx = i; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 read data in reset", rdData, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 read data after reset", rdData, 16'h0000);
    rd(STRAP, 5'd0, 16'h3100, "R1 control default");
    rd(STRAP, 5'd1, 16'h7848, "R1 status default");
    rd(STRAP, 5'd4, 16'h01E1, "R1 advertisement default");
    rd(STRAP, 5'd5, 16'h0080, "R1 partner default");

    // R5: link rises, no bus access during update
    linkUp = 1'b1;
    @(negedge clk);
    rd(STRAP, 5'd1, 16'h786C, "R5 status link up");
    rd(STRAP, 5'd5, 16'h01E1, "R5 partner link up");

    rd(STRAP, 5'd2, ID1, "R10 ID1");
    rd(STRAP, 5'd3, ID2, "R10 ID2");

    rd(STRAP, 5'd6, 16'h0000, "R11 index 6");
    rd(STRAP, 5'd16, 16'h0000, "R11 index 16");
    rd(STRAP, 5'd31, 16'h0000, "R11 index 31");

    rd(5'd0, 5'd0, 16'hFFFF, "R2 address 0");
    rd(5'd31, 5'd2, 16'hFFFF, "R2 address 31");

    wr(STRAP, 5'd0, 16'h1200);
    rd(STRAP, 5'd0, 16'h1200, "R8 control store");
    wr(STRAP, 5'd4, 16'h0061);
    rd(STRAP, 5'd4, 16'h0061, "R8 advertisement store");

    wr(5'd0, 5'd0, 16'h0000);
    wr(5'd18, 5'd4, 16'h0000);
    rd(STRAP, 5'd0, 16'h1200, "R3 control untouched");
    rd(STRAP, 5'd4, 16'h0061, "R3 advertisement untouched");

    wr(STRAP, 5'd1, 16'h0000);
    wr(STRAP, 5'd2, 16'h0000);
    wr(STRAP, 5'd3, 16'hFFFF);
    wr(STRAP, 5'd5, 16'h0000);
    wr(STRAP, 5'd6, 16'hFFFF);
    wr(STRAP, 5'd20, 16'hFFFF);
    rd(STRAP, 5'd1, 16'h786C, "R9 status untouched");
    rd(STRAP, 5'd2, ID1, "R9 ID1 untouched");
    rd(STRAP, 5'd3, ID2, "R9 ID2 untouched");
    rd(STRAP, 5'd5, 16'h01E1, "R9 partner untouched");
    rd(STRAP, 5'd6, 16'h0000, "R9 index 6 still zero");
    rd(STRAP, 5'd0, 16'h1200, "R9 control untouched");

    // R6: link falls
    linkUp = 1'b0;
    @(negedge clk);
    rd(STRAP, 5'd1, 16'h7848, "R6 status link down");
    rd(STRAP, 5'd5, 16'h0080, "R6 partner link down");

    // R7: software reset with link down
    wr(STRAP, 5'd0, 16'h9200);
    rd(STRAP, 5'd0, 16'h3100, "R7 control reloaded");
    rd(STRAP, 5'd4, 16'h01E1, "R7 advertisement reloaded");
    rd(STRAP, 5'd1, 16'h7848, "R7 status link down");

    // R7: software reset in the same cycle the link rises
    wr(STRAP, 5'd0, 16'h0100);
    linkUp = 1'b1;
    wr(STRAP, 5'd0, 16'hFFFF);
    rd(STRAP, 5'd0, 16'h3100, "R7 control reloaded again");
    rd(STRAP, 5'd1, 16'h786C, "R7 status with link");
    rd(STRAP, 5'd5, 16'h01E1, "R7 partner with link");

    // R12: read and write together
    wr(STRAP, 5'd4, 16'h0041);
    rdEn = 1'b1; wrEn = 1'b1; phyAddr = STRAP; regIdx = 5'd4; wrData = 16'h0021;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    check("R12 old value returned", rdData, 16'h0041);
    rd(STRAP, 5'd4, 16'h0021, "R12 new value stored");

    // R4: hold across idle cycles and bus changes
    phyAddr = 5'd0; regIdx = 5'd1;
    repeat (4) @(negedge clk);
    check("R4 read data held", rdData, 16'h0021);

    finishRun();
  end

endmodule